// File: doc/BRIEF.md
# Halfword Atomic Compare-and-Swap Engine

This engine carries out one atomic 16-bit compare-and-swap for a processor pipeline against a simple single-port memory. A request brings the 32-bit instruction word, a 64-bit effective address, the compare operand and the swap operand. The engine checks that the word belongs to the halfword compare-and-swap class and checks the address alignment. It then takes an arbitration lock, reads the halfword and compares it with the low 16 bits of the compare operand. It writes the low 16 bits of the swap operand only when the two are equal. Last, it frees the lock and returns the value it read, zero-extended to 32 bits, for write-back to the compare register.

Two instruction bits carry the ordering qualifiers. With the release qualifier set, a fence handshake must finish before the read. With the acquire qualifier set, a second fence handshake runs after the lock is freed and before the response. Every read sends out a reservation-clear pulse. A request that faults touches neither memory, the lock nor the fences, and it gives no write-back.

Top module: `hcas_unit`

## Requirements
- R1: `req_ready` is high only while the engine is idle. After a request is accepted it stays low until the response cycle has passed, so only one operation is in flight at a time.
- R2: A request is legal only when instruction bits 31:30 = 01, bits 29:23 = 0010001, bit 21 = 1 and bits 14:10 = 11111. Any other request gets fault code 1 and causes no lock, fence or memory activity.
- R3: If the base field (bits 9:5) equals 31, the address is stack-based. A nonzero value in its low 4 bits then gives fault code 2 with no activity. This fault has priority over R4.
- R4: A legal request with address bit 0 set gets fault code 3 with no activity.
- R5: Every memory access happens while `lock_req` and `lock_gnt` are both high. The lock is held from before the read until after the write or skip, and it is low when the response appears.
- R6: A non-faulting request makes exactly one read of the halfword at `req_addr`. The read value is compared with bits 15:0 of `req_cmp` only; the upper bits do not take part.
- R7: The engine writes bits 15:0 of `req_new` to the same address in exactly one write, and only when the compare is equal. On a mismatch it makes no write.
- R8: A successful response has `rsp_wb_en`=1 and `rsp_wb_reg` = instruction bits 20:16. `rsp_wb_data` is the value read, zero-extended to 32 bits. `rsp_match` gives the compare result.
- R9: A faulting response has `rsp_wb_en`=0, `rsp_wb_data`=0, `rsp_match`=0 and a nonzero `rsp_fault`. Memory stays unchanged.
- R10: Each read is followed by a single-cycle `rsv_clr` pulse in the next cycle, whether or not the compare matched.
- R11: When instruction bit 15 (release) is set, one fence handshake with `fence_post`=0 finishes before the read starts.
- R12: When instruction bit 22 (acquire) is set, one fence handshake with `fence_post`=1 takes place after the lock is freed and before `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Engine idle, request can be taken |
| req_insn | input | 32 | Instruction word of the request |
| req_addr | input | ADDR_W | Effective byte address |
| req_cmp | input | RET_W | Compare operand (low HW bits used) |
| req_new | input | RET_W | Swap operand (low HW bits used) |
| lock_req | output | 1 | Arbitration lock request, held across the sequence |
| lock_gnt | input | 1 | Arbitration lock granted |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | HW | Memory write data |
| mem_rdata | input | HW | Memory read data, valid with acknowledge |
| mem_ack | input | 1 | Memory access done |
| fence_req | output | 1 | Ordering fence request |
| fence_post | output | 1 | 0: fence before read (release), 1: fence after unlock (acquire) |
| fence_ack | input | 1 | Fence done |
| rsv_clr | output | 1 | Reservation-clear pulse after each read |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 2 | 0 none, 1 class, 2 stack alignment, 3 halfword alignment |
| rsp_match | output | 1 | Compare was equal |
| rsp_wb_en | output | 1 | Write back to compare register |
| rsp_wb_reg | output | 5 | Index of compare register |
| rsp_wb_data | output | RET_W | Zero-extended old value |

## Verification
If the compare flag or the read capture holds a wrong value, the next cycle shows a wrong write or a missing one on the memory port. The bench's memory image exposes this when the response arrives. If the sequencer leaves its state wrongly, an access can appear without the lock, or a fence can appear on the wrong side of the read, or the ready signal can rise early. The per-clock monitor reports each of these in the cycle it occurs. A stale data or fault register shows up only in the response fields, and the bench compares those once per operation.

// File: rtl/hcas_pkg.sv
package hcas_pkg;

   localparam int INSN_W = 32;

   // fixed fields of the halfword compare-and-swap class
   localparam logic [1:0] SIZE_HALF = 2'b01;
   localparam logic [6:0] OPC_CAS   = 7'b0010001;
   localparam logic [4:0] RT2_ONES  = 5'b11111;
   localparam logic [4:0] SP_INDEX  = 5'd31;

   // bit positions that other units also decode
   localparam int BIT_ACQ = 22;
   localparam int BIT_REL = 15;
   localparam int BIT_FIX = 21;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_CHECK,
      ST_PRE_FENCE,
      ST_LOCK,
      ST_READ,
      ST_COMPARE,
      ST_WRITE,
      ST_SKIP,
      ST_UNLOCK,
      ST_POST_FENCE,
      ST_DONE
   } hcas_state_e;

   typedef enum logic [1:0] {
      FLT_NONE     = 2'd0,
      FLT_CLASS    = 2'd1,
      FLT_SP_ALIGN = 2'd2,
      FLT_HW_ALIGN = 2'd3
   } hcas_fault_e;

endpackage

// File: rtl/hcas_decode.sv
module hcas_decode
   import hcas_pkg::*;
#(
   parameter int ADDR_W        = 64,
   parameter int SP_ALIGN_LOG2 = 4
) (
   input  logic [INSN_W-1:0] insn,
   input  logic [ADDR_W-1:0] addr,
   output logic              acq,
   output logic              rel,
   output logic [4:0]        rs_idx,
   output hcas_fault_e       fault
);

   logic class_ok;
   logic sp_base;
   logic sp_mis;
   logic unused_rt;

   assign unused_rt = ^insn[4:0];

   assign class_ok = (insn[31:30] == SIZE_HALF) &&
                     (insn[29:23] == OPC_CAS)   &&
                     insn[BIT_FIX]              &&
                     (insn[14:10] == RT2_ONES);

   assign sp_base = (insn[9:5] == SP_INDEX);
   assign acq     = insn[BIT_ACQ];
   assign rel     = insn[BIT_REL];
   assign rs_idx  = insn[20:16];

   generate
      if (SP_ALIGN_LOG2 > 0) begin : g_sp_chk
         assign sp_mis = sp_base && (|addr[SP_ALIGN_LOG2-1:0]);
      end else begin : g_sp_nochk
         assign sp_mis = 1'b0;
      end
   endgenerate

   always_comb begin
      if (!class_ok)     fault = FLT_CLASS;
      else if (sp_mis)   fault = FLT_SP_ALIGN;
      else if (addr[0])  fault = FLT_HW_ALIGN;
      else               fault = FLT_NONE;
   end

endmodule

// File: rtl/hcas_ctrl.sv
module hcas_ctrl
   import hcas_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic req_valid,
   input  logic faulted,
   input  logic acq,
   input  logic rel,
   input  logic cmp_eq,
   input  logic lock_gnt,
   input  logic mem_ack,
   input  logic fence_ack,
   output logic req_ready,
   output logic req_fire,
   output logic lock_req,
   output logic mem_req,
   output logic mem_we,
   output logic fence_req,
   output logic fence_post,
   output logic rsv_clr,
   output logic cap_read,
   output logic cap_cmp,
   output logic rsp_valid
);

   hcas_state_e st_q, st_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE:       if (req_valid)  st_d = ST_CHECK;
         ST_CHECK: begin
            if (faulted)    st_d = ST_DONE;
            else if (rel)   st_d = ST_PRE_FENCE;
            else            st_d = ST_LOCK;
         end
         ST_PRE_FENCE:  if (fence_ack)  st_d = ST_LOCK;
         ST_LOCK:       if (lock_gnt)   st_d = ST_READ;
         ST_READ:       if (mem_ack)    st_d = ST_COMPARE;
         ST_COMPARE:    st_d = cmp_eq ? ST_WRITE : ST_SKIP;
         ST_WRITE:      if (mem_ack)    st_d = ST_UNLOCK;
         ST_SKIP:       st_d = ST_UNLOCK;
         ST_UNLOCK:     st_d = acq ? ST_POST_FENCE : ST_DONE;
         ST_POST_FENCE: if (fence_ack)  st_d = ST_DONE;
         ST_DONE:       st_d = ST_IDLE;
         default:       st_d = ST_IDLE;
      endcase
   end

   assign req_ready  = (st_q == ST_IDLE);
   assign req_fire   = req_ready && req_valid;
   assign lock_req   = (st_q == ST_LOCK) || (st_q == ST_READ) || (st_q == ST_COMPARE) ||
                       (st_q == ST_WRITE) || (st_q == ST_SKIP);
   assign mem_req    = (st_q == ST_READ) || (st_q == ST_WRITE);
   assign mem_we     = (st_q == ST_WRITE);
   assign fence_req  = (st_q == ST_PRE_FENCE) || (st_q == ST_POST_FENCE);
   assign fence_post = (st_q == ST_POST_FENCE);
   assign rsv_clr    = (st_q == ST_COMPARE);
   assign cap_read   = (st_q == ST_READ) && mem_ack;
   assign cap_cmp    = (st_q == ST_COMPARE);
   assign rsp_valid  = (st_q == ST_DONE);

endmodule

// File: rtl/hcas_dpath.sv
module hcas_dpath
   import hcas_pkg::*;
#(
   parameter int ADDR_W = 64,
   parameter int HW     = 16,
   parameter int RET_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_fire,
   input  logic [INSN_W-1:0] req_insn,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [RET_W-1:0]  req_cmp,
   input  logic [RET_W-1:0]  req_new,
   input  logic              cap_read,
   input  logic              cap_cmp,
   input  logic [HW-1:0]     mem_rdata,
   output logic [INSN_W-1:0] insn_q,
   output logic [ADDR_W-1:0] addr_q,
   output logic [HW-1:0]     new_q,
   output logic              cmp_eq,
   output logic              match_q,
   output logic [RET_W-1:0]  old_ext
);

   logic [HW-1:0] cmp_q;
   logic [HW-1:0] rd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         insn_q <= '0;
         addr_q <= '0;
         cmp_q  <= '0;
         new_q  <= '0;
      end else if (req_fire) begin
         insn_q <= req_insn;
         addr_q <= req_addr;
         cmp_q  <= req_cmp[HW-1:0];
         new_q  <= req_new[HW-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        rd_q <= '0;
      else if (req_fire) rd_q <= '0;
      else if (cap_read) rd_q <= mem_rdata;
   end

   assign cmp_eq = (rd_q == cmp_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        match_q <= 1'b0;
      else if (req_fire) match_q <= 1'b0;
      else if (cap_cmp)  match_q <= cmp_eq;
   end

   generate
      if (RET_W > HW) begin : g_zext
         logic unused_hi;
         assign unused_hi = ^{req_cmp[RET_W-1:HW], req_new[RET_W-1:HW]};
         assign old_ext   = {{(RET_W-HW){1'b0}}, rd_q};
      end else begin : g_flat
         assign old_ext = rd_q;
      end
   endgenerate

endmodule

// File: rtl/hcas_unit.sv
module hcas_unit
   import hcas_pkg::*;
#(
   parameter int ADDR_W        = 64,
   parameter int HW            = 16,
   parameter int RET_W         = 32,
   parameter int SP_ALIGN_LOG2 = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [31:0]       req_insn,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [RET_W-1:0]  req_cmp,
   input  logic [RET_W-1:0]  req_new,
   output logic              lock_req,
   input  logic              lock_gnt,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [HW-1:0]     mem_wdata,
   input  logic [HW-1:0]     mem_rdata,
   input  logic              mem_ack,
   output logic              fence_req,
   output logic              fence_post,
   input  logic              fence_ack,
   output logic              rsv_clr,
   output logic              rsp_valid,
   output logic [1:0]        rsp_fault,
   output logic              rsp_match,
   output logic              rsp_wb_en,
   output logic [4:0]        rsp_wb_reg,
   output logic [RET_W-1:0]  rsp_wb_data
);

   initial begin
      if (RET_W < HW)               $error("hcas_unit: RET_W must cover HW");
      if (ADDR_W <= SP_ALIGN_LOG2)  $error("hcas_unit: ADDR_W too small");
      if (HW < 2)                   $error("hcas_unit: HW too small");
   end

   logic [INSN_W-1:0] insn_q;
   logic [ADDR_W-1:0] addr_q;
   logic [HW-1:0]     new_q;
   logic              cmp_eq, match_q;
   logic [RET_W-1:0]  old_ext;
   logic              acq, rel;
   logic [4:0]        rs_idx;
   hcas_fault_e       fault;
   logic              faulted;
   logic              req_fire, cap_read, cap_cmp;

   hcas_decode #(.ADDR_W(ADDR_W), .SP_ALIGN_LOG2(SP_ALIGN_LOG2)) u_decode (
      .insn   (insn_q),
      .addr   (addr_q),
      .acq    (acq),
      .rel    (rel),
      .rs_idx (rs_idx),
      .fault  (fault)
   );

   assign faulted = (fault != FLT_NONE);

   hcas_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .faulted    (faulted),
      .acq        (acq),
      .rel        (rel),
      .cmp_eq     (cmp_eq),
      .lock_gnt   (lock_gnt),
      .mem_ack    (mem_ack),
      .fence_ack  (fence_ack),
      .req_ready  (req_ready),
      .req_fire   (req_fire),
      .lock_req   (lock_req),
      .mem_req    (mem_req),
      .mem_we     (mem_we),
      .fence_req  (fence_req),
      .fence_post (fence_post),
      .rsv_clr    (rsv_clr),
      .cap_read   (cap_read),
      .cap_cmp    (cap_cmp),
      .rsp_valid  (rsp_valid)
   );

   hcas_dpath #(.ADDR_W(ADDR_W), .HW(HW), .RET_W(RET_W)) u_dpath (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_fire  (req_fire),
      .req_insn  (req_insn),
      .req_addr  (req_addr),
      .req_cmp   (req_cmp),
      .req_new   (req_new),
      .cap_read  (cap_read),
      .cap_cmp   (cap_cmp),
      .mem_rdata (mem_rdata),
      .insn_q    (insn_q),
      .addr_q    (addr_q),
      .new_q     (new_q),
      .cmp_eq    (cmp_eq),
      .match_q   (match_q),
      .old_ext   (old_ext)
   );

   assign mem_addr    = addr_q;
   assign mem_wdata   = new_q;
   assign rsp_fault   = rsp_valid ? fault : FLT_NONE;
   assign rsp_wb_en   = rsp_valid && !faulted;
   assign rsp_wb_reg  = rs_idx;
   assign rsp_wb_data = rsp_wb_en ? old_ext : '0;
   assign rsp_match   = rsp_wb_en && match_q;

endmodule

// File: rtl/hcas_chk.sv
module hcas_chk #(
   parameter int HW    = 16,
   parameter int RET_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             req_ready,
   input logic [31:0]      req_insn,
   input logic [RET_W-1:0] req_cmp,
   input logic             lock_req,
   input logic             lock_gnt,
   input logic             mem_req,
   input logic             mem_we,
   input logic             mem_ack,
   input logic [HW-1:0]    mem_rdata,
   input logic             fence_req,
   input logic             fence_post,
   input logic             fence_ack,
   input logic             rsv_clr,
   input logic             rsp_valid,
   input logic [1:0]       rsp_fault,
   input logic             rsp_match,
   input logic             rsp_wb_en,
   input logic [RET_W-1:0] rsp_wb_data
);

   logic [HW-1:0] c_cmp, c_rd;
   logic          c_acq, c_rel, c_pre, c_post, c_touch, c_read_done;
   logic          unused_chk;

   assign unused_chk = ^{req_insn, req_cmp};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         c_cmp <= '0; c_rd <= '0; c_acq <= 1'b0; c_rel <= 1'b0;
         c_pre <= 1'b0; c_post <= 1'b0; c_touch <= 1'b0; c_read_done <= 1'b0;
      end else if (req_valid && req_ready) begin
         c_cmp <= req_cmp[HW-1:0];
         c_acq <= req_insn[22];
         c_rel <= req_insn[15];
         c_pre <= 1'b0; c_post <= 1'b0; c_touch <= 1'b0; c_read_done <= 1'b0;
      end else begin
         if (mem_req && !mem_we && mem_ack) begin
            c_rd        <= mem_rdata;
            c_read_done <= 1'b1;
         end
         if (fence_req && fence_ack && !fence_post) c_pre  <= 1'b1;
         if (fence_req && fence_ack && fence_post)  c_post <= 1'b1;
         if (lock_req || mem_req || fence_req)      c_touch <= 1'b1;
      end
   end

   assert_one_inflight_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   assert_fault_untouched_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault != 2'd0) |-> !c_touch);

   assert_access_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (lock_req && lock_gnt));

   assert_unlocked_resp_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !lock_req);

   assert_write_on_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> (c_read_done && c_rd == c_cmp));

   assert_zero_extend_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_wb_en) |-> ((rsp_wb_data >> HW) == '0));

   assert_fault_no_wb_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault != 2'd0) |-> (!rsp_wb_en && !rsp_match));

   assert_rsv_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rsv_clr |=> !rsv_clr);

   assert_rsv_after_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rsv_clr |-> c_read_done);

   assert_release_first_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && c_rel) |-> c_pre);

   assert_acquire_last_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && c_acq && rsp_fault == 2'd0) |-> c_post);

endmodule

bind hcas_unit hcas_chk #(.HW(HW), .RET_W(RET_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .req_ready   (req_ready),
   .req_insn    (req_insn),
   .req_cmp     (req_cmp),
   .lock_req    (lock_req),
   .lock_gnt    (lock_gnt),
   .mem_req     (mem_req),
   .mem_we      (mem_we),
   .mem_ack     (mem_ack),
   .mem_rdata   (mem_rdata),
   .fence_req   (fence_req),
   .fence_post  (fence_post),
   .fence_ack   (fence_ack),
   .rsv_clr     (rsv_clr),
   .rsp_valid   (rsp_valid),
   .rsp_fault   (rsp_fault),
   .rsp_match   (rsp_match),
   .rsp_wb_en   (rsp_wb_en),
   .rsp_wb_data (rsp_wb_data)
);

// File: tb/hcas_unit_tb.sv
`timescale 1ns/1ps
module hcas_unit_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_insn = '0;
   logic [63:0] req_addr = '0;
   logic [31:0] req_cmp = '0;
   logic [31:0] req_new = '0;
   logic        lock_req;
   logic        lock_gnt = 1'b0;
   logic        mem_req, mem_we;
   logic [63:0] mem_addr;
   logic [15:0] mem_wdata;
   logic [15:0] mem_rdata = '0;
   logic        mem_ack = 1'b0;
   logic        fence_req, fence_post;
   logic        fence_ack = 1'b0;
   logic        rsv_clr, rsp_valid, rsp_match, rsp_wb_en;
   logic [1:0]  rsp_fault;
   logic [4:0]  rsp_wb_reg;
   logic [31:0] rsp_wb_data;

   always #2 clk = ~clk;

   hcas_unit u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_insn(req_insn), .req_addr(req_addr), .req_cmp(req_cmp), .req_new(req_new),
      .lock_req(lock_req), .lock_gnt(lock_gnt), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
      .fence_req(fence_req), .fence_post(fence_post), .fence_ack(fence_ack),
      .rsv_clr(rsv_clr), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
      .rsp_match(rsp_match), .rsp_wb_en(rsp_wb_en), .rsp_wb_reg(rsp_wb_reg),
      .rsp_wb_data(rsp_wb_data)
   );

   int n_checks = 0;
   int n_err = 0;
   int cyc = 0;
   int lock_delay = 0;
   int lock_cnt = 0;
   bit busy = 0;
   bit done = 0;

   // per-operation event record kept by the environment
   int n_rd, n_wr, n_pre, n_post, n_rsv, n_lock;
   int t_rd, t_pre, t_post;
   bit post_locked;

   logic [15:0] mem_m [logic [62:0]];

   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [15:0] mem_rd(input logic [63:0] a);
      if (mem_m.exists(a[63:1])) return mem_m[a[63:1]];
      return a[16:1] ^ 16'hA55A;
   endfunction

   function automatic logic [31:0] mk(input logic acq, input logic rel, input logic [4:0] rs,
                                      input logic [4:0] rn, input logic [4:0] rt);
      return {2'b01, 7'b0010001, acq, 1'b1, rs, rel, 5'b11111, rn, rt};
   endfunction

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // environment: memory, lock arbiter and fence responder, plus per-clock checks
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n) begin
            if (busy) check("R1 ready low while busy", req_ready, 1'b0);
            if (mem_req) check("R5 access under grant", lock_gnt, 1'b1);
            if (lock_req) n_lock++;
            if (rsv_clr) n_rsv++;
         end
         if (mem_req && !mem_ack) begin
            if (mem_we) begin
               n_wr++;
               mem_m[mem_addr[63:1]] = mem_wdata;
            end else begin
               n_rd++;
               t_rd = cyc;
               mem_rdata = mem_rd(mem_addr);
            end
            mem_ack = 1'b1;
         end else begin
            mem_ack = 1'b0;
         end
         if (fence_req && !fence_ack) begin
            if (fence_post) begin
               n_post++; t_post = cyc; post_locked = lock_req;
            end else begin
               n_pre++; t_pre = cyc;
            end
            fence_ack = 1'b1;
         end else begin
            fence_ack = 1'b0;
         end
         if (lock_req) begin
            if (lock_cnt >= lock_delay) lock_gnt = 1'b1;
            else lock_cnt++;
         end else begin
            lock_gnt = 1'b0;
            lock_cnt = 0;
         end
      end
   end

   task automatic run_op(input logic [31:0] insn, input logic [63:0] addr,
                         input logic [31:0] cmp, input logic [31:0] nw);
      bit legal;
      int exp_f;
      logic [15:0] old;
      bit match;
      int to;
      int rsp_cyc;
      string ft;
      legal = (insn[31:30] == 2'b01) && (insn[29:23] == 7'b0010001) && insn[21] &&
              (insn[14:10] == 5'h1f);
      if (!legal) exp_f = 1;
      else if (insn[9:5] == 5'd31 && addr[3:0] != 4'd0) exp_f = 2;
      else if (addr[0]) exp_f = 3;
      else exp_f = 0;
      ft = (exp_f == 1) ? "R2" : (exp_f == 2) ? "R3" : (exp_f == 3) ? "R4" : "R8";
      old = mem_rd(addr);
      match = (old == cmp[15:0]);
      n_rd = 0; n_wr = 0; n_pre = 0; n_post = 0; n_rsv = 0; n_lock = 0;
      t_rd = 0; t_pre = 0; t_post = 0; post_locked = 0;

      @(negedge clk);
      req_valid = 1'b1; req_insn = insn; req_addr = addr; req_cmp = cmp; req_new = nw;
      while (!req_ready) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      busy = 1;
      to = 0;
      while (!rsp_valid && to < 300) begin
         @(negedge clk);
         to++;
      end
      busy = 0;
      rsp_cyc = cyc;
      if (!rsp_valid) begin
         check("R1 response timeout", 1, 0);
         return;
      end
      check({ft, " fault code"}, rsp_fault, exp_f);
      if (exp_f != 0) begin
         check("R9 no write-back", {rsp_wb_en, rsp_match}, 2'b00);
         check("R9 data zero", rsp_wb_data, 0);
         check({ft, " no side effects"}, n_rd + n_wr + n_pre + n_post + n_lock, 0);
         check("R9 memory unchanged", mem_rd(addr), old);
      end else begin
         check("R5 lock taken", n_lock > 0, 1);
         check("R6 one read", n_rd, 1);
         check("R7 write count", n_wr, match);
         check("R7 memory after", mem_rd(addr), match ? nw[15:0] : old);
         check("R8 write-back", {rsp_wb_en, rsp_match, rsp_wb_reg}, {1'b1, match, insn[20:16]});
         check("R8 zero-extended old", rsp_wb_data, {16'h0, old});
         check("R10 reservation pulse", n_rsv, 1);
         check("R11 pre fence", n_pre, insn[15]);
         if (insn[15]) check("R11 fence before read", t_pre < t_rd, 1);
         check("R12 post fence", n_post, insn[22]);
         if (insn[22]) begin
            check("R12 lock freed at fence", post_locked, 0);
            check("R12 fence before response", t_post < rsp_cyc, 1);
         end
      end
      @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 ready after reset", req_ready, 1'b1);
      check("R5 idle outputs after reset",
            {lock_req, mem_req, fence_req, rsv_clr, rsp_valid}, 5'b0);

      // plain, match; upper bits of swap operand must not reach memory (R7)
      run_op(mk(0, 0, 5'd3, 5'd2, 5'd4), 64'h1000, {16'h0, mem_rd(64'h1000)}, 32'h7777BEEF);
      // plain, mismatch (R6, R7)
      run_op(mk(0, 0, 5'd7, 5'd2, 5'd4), 64'h1000, {16'h0, ~mem_rd(64'h1000)}, 32'h1111);
      // acquire only, match
      run_op(mk(1, 0, 5'd9, 5'd1, 5'd2), 64'h1002, {16'h0, mem_rd(64'h1002)}, 32'h0000CAFE);
      // release only, mismatch
      run_op(mk(0, 1, 5'd10, 5'd1, 5'd2), 64'h1004, 32'h0, 32'h0000F00D);
      // both qualifiers, slow grant, match
      lock_delay = 3;
      run_op(mk(1, 1, 5'd31, 5'd6, 5'd0), 64'h1006, {16'h0, mem_rd(64'h1006)}, 32'h00001234);
      lock_delay = 0;
      // wrong size field (R2)
      run_op(mk(0, 0, 5'd1, 5'd2, 5'd3) ^ 32'hC000_0000, 64'h1000, 32'h0, 32'h0);
      // bit 21 clear (R2)
      run_op(mk(1, 1, 5'd1, 5'd2, 5'd3) & ~32'h0020_0000, 64'h1000, 32'h0, 32'h0);
      // stack base misaligned (R3)
      run_op(mk(0, 0, 5'd4, 5'd31, 5'd3), 64'h2002, {16'h0, mem_rd(64'h2002)}, 32'h5555);
      // stack base aligned, match (R3)
      run_op(mk(0, 1, 5'd4, 5'd31, 5'd3), 64'h2010, {16'h0, mem_rd(64'h2010)}, 32'h6666);
      // odd halfword address (R4)
      run_op(mk(1, 0, 5'd5, 5'd2, 5'd3), 64'h1001, 32'h0, 32'h0);
      // stack base odd address: stack fault wins (R3 over R4)
      run_op(mk(0, 0, 5'd5, 5'd31, 5'd3), 64'h2003, 32'h0, 32'h0);
      // upper compare bits ignored: match on low half only (R6)
      run_op(mk(0, 0, 5'd6, 5'd2, 5'd3), 64'h1008, {16'hABCD, mem_rd(64'h1008)}, 32'h00004321);
      // high address bits carried to memory
      run_op(mk(1, 1, 5'd8, 5'd2, 5'd3), 64'hFFFF_0000_0000_1230,
             {16'h0, mem_rd(64'hFFFF_0000_0000_1230)}, 32'h00009999);
      // second swap on same location sees the earlier write
      run_op(mk(0, 0, 5'd3, 5'd2, 5'd4), 64'h1000, 32'h0000BEEF, 32'h00000101);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   end

endmodule